// File: doc/BRIEF.md
# Priority Control-Word Inserter with Single-Error-Correcting Special Characters

This block sits on the transmit side of a 16-bit serial link and chooses the word sent in each clock cycle. Four sources compete for that slot. The first is a framed packet stream offered with a valid/ready handshake. The second is a pair of acknowledge characters, positive and negative. The third is the link-initialisation filler. The fourth is a deterministic-latency message that carries a 4-bit message number. When none of them has anything to send, the line is filled with an idle character. The deterministic-latency message ranks above everything else. It always leaves a fixed number of cycles after its request, and it may land between two words of a packet, in which case the packet is simply held for one slot.

Every special character is a 16-bit codeword sent with the k-flag set. The codeword is built from two Hamming(7,4) blocks, so any two valid characters differ in at least three bits. A receive-side decoder works on the incoming word stream. It repairs any single flipped bit, reports the character type, the message number and a corrected pulse, and flags as uncorrectable any word that lies two or more bits from every valid character.

Top module: `ctl_word_mux`

## Requirements
- R1: While rst_n is low, tx_word holds the idle codeword with tx_k = 1, pkt_ready is 1, and rx_char_valid, rx_corr, rx_uncorr, rx_type and rx_dlm_num are all 0.
- R2: A dlm_req pulse sampled at clock edge N makes tx_word, from edge N+DLM_LAT on (N+2 by default), the message codeword carrying the dlm_num sampled at edge N, with tx_k = 1. This holds whatever else is pending, and for requests on consecutive edges.
- R3: A packet word accepted at an edge (pkt_valid and pkt_ready both high) appears unchanged on tx_word with tx_k = 0 after that same edge. pkt_last marks the final word of a packet.
- R4: pkt_ready is low in the cycle before an edge at which a message is due, so the offered packet word waits one slot and is then sent intact.
- R5: ack_req and nack_req pulses stay pending until their character is sent. The characters go out only when no packet is open (after a final word, or before a first word), positive before negative, and ahead of a waiting packet.
- R6: With nothing pending, the idle character is sent. While link_init is high, the initialisation character is sent instead, packets and acknowledges wait (pkt_ready = 0), and messages still go out.
- R7: A special codeword is {2'b00, H(payload), H(class)}, where H maps nibble d to 7 bits: data d[0], d[1], d[2], d[3] sit at bits 2, 4, 5 and 6. Bit 0 is d0^d1^d3, bit 1 is d0^d2^d3 and bit 3 is d1^d2^d3. The class codes are idle 3, init 5, positive ack 6, negative ack 9 and message A (hex). Payload is 0 except for a message, where it is the message number.
- R8: One cycle after a valid codeword arrives with rx_k = 1, rx_char_valid = 1 and rx_type gives the character (idle 0, init 1, positive ack 2, negative ack 3, message 4). rx_dlm_num gives the number for a message and 0 otherwise, and rx_corr = 0.
- R9: A received word one bit away from a valid codeword gives the same outputs as that codeword, plus rx_corr = 1.
- R10: A received word with rx_k = 1 that lies two or more bits from every valid codeword gives rx_uncorr = 1 with rx_char_valid = 0, rx_corr = 0, rx_type = 0 and rx_dlm_num = 0.
- R11: A word received with rx_k = 0 drives all decoder outputs to 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A packet word is offered |
| pkt_word | input | 16 | Offered packet word |
| pkt_last | input | 1 | Offered word closes its packet |
| pkt_ready | output | 1 | Offered word is taken at the next edge |
| ack_req | input | 1 | Pulse: queue a positive acknowledge |
| nack_req | input | 1 | Pulse: queue a negative acknowledge |
| link_init | input | 1 | Link training: send init filler, hold packets |
| dlm_req | input | 1 | Pulse: insert a deterministic-latency message |
| dlm_num | input | 4 | Message number sampled with dlm_req |
| tx_word | output | 16 | Outgoing link word |
| tx_k | output | 1 | Outgoing word is a special character |
| rx_word | input | 16 | Incoming link word |
| rx_k | input | 1 | Incoming word is flagged special |
| rx_char_valid | output | 1 | A special character was decoded |
| rx_type | output | 3 | Decoded character type |
| rx_dlm_num | output | 4 | Decoded message number |
| rx_corr | output | 1 | A single-bit error was repaired |
| rx_uncorr | output | 1 | Special word could not be decoded |

## Verification
The sharpest overlap on the transmit side is a due message meeting a packet word that is already offered mid-packet, with an acknowledge queued in the same cycle. The bench provokes it by pulsing dlm_req and ack_req together while a packet streams. It also fires requests on back-to-back edges and during source gaps and link training. A behavioural reference model, built on queues of due edges and a packet queue, predicts tx_word, tx_k and pkt_ready for every cycle, and the bench compares against that prediction. On the receive side, valid codewords, every single-bit flip of each character and a set of double flips are judged by a brute-force nearest-codeword search.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BLK_W  = 7;
  localparam int unsigned NBLK   = 2;
  localparam int unsigned TOP_LSB = NBLK * BLK_W;
  localparam int unsigned TYPE_W = 3;

  typedef enum logic [TYPE_W-1:0] {
    CH_IDLE = 3'd0,
    CH_INIT = 3'd1,
    CH_ACK  = 3'd2,
    CH_NACK = 3'd3,
    CH_DLM  = 3'd4
  } char_e;

  localparam logic [NIB_W-1:0] CLS_IDLE = 4'h3;
  localparam logic [NIB_W-1:0] CLS_INIT = 4'h5;
  localparam logic [NIB_W-1:0] CLS_ACK  = 4'h6;
  localparam logic [NIB_W-1:0] CLS_NACK = 4'h9;
  localparam logic [NIB_W-1:0] CLS_DLM  = 4'hA;

  // single-error-correcting block: data at 2,4,5,6, parity at 0,1,3
  function automatic logic [BLK_W-1:0] h74_enc(input logic [NIB_W-1:0] d);
    logic [BLK_W-1:0] c;
    c[2] = d[0];
    c[4] = d[1];
    c[5] = d[2];
    c[6] = d[3];
    c[0] = d[0] ^ d[1] ^ d[3];
    c[1] = d[0] ^ d[2] ^ d[3];
    c[3] = d[1] ^ d[2] ^ d[3];
    return c;
  endfunction

  // syndrome value is the 1-based position of a single flipped bit
  function automatic logic [2:0] h74_syn(input logic [BLK_W-1:0] c);
    logic [2:0] s;
    s[0] = c[0] ^ c[2] ^ c[4] ^ c[6];
    s[1] = c[1] ^ c[2] ^ c[5] ^ c[6];
    s[2] = c[3] ^ c[4] ^ c[5] ^ c[6];
    return s;
  endfunction

  function automatic logic [NIB_W-1:0] h74_data(input logic [BLK_W-1:0] c);
    return {c[6], c[5], c[4], c[2]};
  endfunction

  function automatic logic [NIB_W-1:0] class_of(input char_e t);
    logic [NIB_W-1:0] k;
    case (t)
      CH_INIT: k = CLS_INIT;
      CH_ACK:  k = CLS_ACK;
      CH_NACK: k = CLS_NACK;
      CH_DLM:  k = CLS_DLM;
      default: k = CLS_IDLE;
    endcase
    return k;
  endfunction

  function automatic logic [WORD_W-1:0] char_word(input char_e t,
                                                  input logic [NIB_W-1:0] num);
    logic [NIB_W-1:0] pay;
    pay = (t == CH_DLM) ? num : '0;
    return {{(WORD_W - TOP_LSB){1'b0}}, h74_enc(pay), h74_enc(class_of(t))};
  endfunction

endpackage

// File: rtl/ctlw_dlm_pipe.sv
module ctlw_dlm_pipe
  import ctlw_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [NIB_W-1:0] num,
  output logic             due,
  output logic [NIB_W-1:0] due_num
);

  logic [DEPTH-1:0] vld_q;
  logic [NIB_W-1:0] num_q [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic             vld_d;
      logic [NIB_W-1:0] num_d;
      if (s == 0) begin : g_head
        assign vld_d = req;
        assign num_d = num;
      end else begin : g_tail
        assign vld_d = vld_q[s-1];
        assign num_d = num_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[s] <= 1'b0;
          num_q[s] <= '0;
        end else begin
          vld_q[s] <= vld_d;
          if (vld_d) num_q[s] <= num_d;
        end
      end
    end
  endgenerate

  assign due     = vld_q[DEPTH-1];
  assign due_num = num_q[DEPTH-1];

endmodule

// File: rtl/ctlw_tx_arb.sv
module ctlw_tx_arb
  import ctlw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dlm_due,
  input  logic [NIB_W-1:0]  dlm_num,
  input  logic              ack_req,
  input  logic              nack_req,
  input  logic              link_init,
  input  logic              pkt_valid,
  input  logic [WORD_W-1:0] pkt_word,
  input  logic              pkt_last,
  output logic              pkt_ready,
  output logic              pkt_open,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_k
);

  logic              ack_q, nack_q, open_q;
  logic              ack_d, nack_d, open_d, open_en;
  logic [WORD_W-1:0] word_q, word_d;
  logic              k_q, k_d;
  logic              ctl_go, take;

  assign ctl_go    = !dlm_due && !link_init && !open_q && (ack_q || nack_q);
  assign pkt_ready = !dlm_due && !link_init && !ctl_go;
  assign take      = pkt_valid && pkt_ready;

  always_comb begin
    word_d = char_word(link_init ? CH_INIT : CH_IDLE, '0);
    k_d    = 1'b1;
    if (dlm_due) begin
      word_d = char_word(CH_DLM, dlm_num);
    end else if (ctl_go) begin
      word_d = char_word(ack_q ? CH_ACK : CH_NACK, '0);
    end else if (take) begin
      word_d = pkt_word;
      k_d    = 1'b0;
    end
  end

  always_comb begin
    ack_d   = (ack_q && !(ctl_go && ack_q)) || ack_req;
    nack_d  = (nack_q && !(ctl_go && !ack_q)) || nack_req;
    open_en = take;
    open_d  = !pkt_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      nack_q <= 1'b0;
      open_q <= 1'b0;
      word_q <= char_word(CH_IDLE, '0);
      k_q    <= 1'b1;
    end else begin
      ack_q  <= ack_d;
      nack_q <= nack_d;
      word_q <= word_d;
      k_q    <= k_d;
      if (open_en) open_q <= open_d;
    end
  end

  assign pkt_open = open_q;
  assign tx_word  = word_q;
  assign tx_k     = k_q;

endmodule

// File: rtl/ctlw_rx_dec.sv
module ctlw_rx_dec
  import ctlw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_k,
  output logic              rx_char_valid,
  output logic [TYPE_W-1:0] rx_type,
  output logic [NIB_W-1:0]  rx_dlm_num,
  output logic              rx_corr,
  output logic              rx_uncorr
);

  logic [BLK_W-1:0]          blk_fix [NBLK];
  logic [NBLK-1:0]           blk_err;
  logic [WORD_W-TOP_LSB-1:0] top_bits;
  logic                      multi, single;
  logic [NIB_W-1:0]          cls, pay;
  logic                      known, ok;
  char_e                     kind;

  generate
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
      logic [BLK_W-1:0] raw;
      logic [2:0]       syn;
      assign raw        = rx_word[b*BLK_W +: BLK_W];
      assign syn        = h74_syn(raw);
      assign blk_err[b] = |syn;
      assign blk_fix[b] = (syn == 3'd0) ? raw : (raw ^ (7'b1 << (syn - 3'd1)));
    end
  endgenerate

  assign top_bits = rx_word[WORD_W-1:TOP_LSB];
  assign multi    = $countones({blk_err, top_bits}) > 1;
  assign single   = $countones({blk_err, top_bits}) == 1;
  assign cls      = h74_data(blk_fix[0]);
  assign pay      = h74_data(blk_fix[1]);

  always_comb begin
    known = 1'b1;
    case (cls)
      CLS_IDLE: kind = CH_IDLE;
      CLS_INIT: kind = CH_INIT;
      CLS_ACK:  kind = CH_ACK;
      CLS_NACK: kind = CH_NACK;
      CLS_DLM:  kind = CH_DLM;
      default: begin
        kind  = CH_IDLE;
        known = 1'b0;
      end
    endcase
    ok = !multi && known && ((kind == CH_DLM) || (pay == '0));
  end

  logic              v_d, c_d, u_d;
  logic [TYPE_W-1:0] t_d;
  logic [NIB_W-1:0]  n_d;

  always_comb begin
    v_d = 1'b0;
    c_d = 1'b0;
    u_d = 1'b0;
    t_d = '0;
    n_d = '0;
    if (rx_k) begin
      if (ok) begin
        v_d = 1'b1;
        c_d = single;
        t_d = kind;
        n_d = (kind == CH_DLM) ? pay : '0;
      end else begin
        u_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_char_valid <= 1'b0;
      rx_corr       <= 1'b0;
      rx_uncorr     <= 1'b0;
      rx_type       <= '0;
      rx_dlm_num    <= '0;
    end else begin
      rx_char_valid <= v_d;
      rx_corr       <= c_d;
      rx_uncorr     <= u_d;
      rx_type       <= t_d;
      rx_dlm_num    <= n_d;
    end
  end

endmodule

// File: rtl/ctl_word_mux.sv
module ctl_word_mux
  import ctlw_pkg::*;
#(
  parameter int unsigned DLM_LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pkt_valid,
  input  logic [15:0] pkt_word,
  input  logic        pkt_last,
  output logic        pkt_ready,
  input  logic        ack_req,
  input  logic        nack_req,
  input  logic        link_init,
  input  logic        dlm_req,
  input  logic [3:0]  dlm_num,
  output logic [15:0] tx_word,
  output logic        tx_k,
  input  logic [15:0] rx_word,
  input  logic        rx_k,
  output logic        rx_char_valid,
  output logic [2:0]  rx_type,
  output logic [3:0]  rx_dlm_num,
  output logic        rx_corr,
  output logic        rx_uncorr
);

  logic             dlm_due;
  logic [NIB_W-1:0] dlm_due_num;
  logic             pkt_open;

  ctlw_dlm_pipe #(.DEPTH(DLM_LAT)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (dlm_req),
    .num     (dlm_num),
    .due     (dlm_due),
    .due_num (dlm_due_num)
  );

  ctlw_tx_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .dlm_due   (dlm_due),
    .dlm_num   (dlm_due_num),
    .ack_req   (ack_req),
    .nack_req  (nack_req),
    .link_init (link_init),
    .pkt_valid (pkt_valid),
    .pkt_word  (pkt_word),
    .pkt_last  (pkt_last),
    .pkt_ready (pkt_ready),
    .pkt_open  (pkt_open),
    .tx_word   (tx_word),
    .tx_k      (tx_k)
  );

  ctlw_rx_dec u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_word       (rx_word),
    .rx_k          (rx_k),
    .rx_char_valid (rx_char_valid),
    .rx_type       (rx_type),
    .rx_dlm_num    (rx_dlm_num),
    .rx_corr       (rx_corr),
    .rx_uncorr     (rx_uncorr)
  );

endmodule

// File: rtl/ctlw_checker.sv
module ctlw_checker
  import ctlw_pkg::*;
#(
  parameter int unsigned DLM_LAT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        pkt_valid,
  input logic [15:0] pkt_word,
  input logic        pkt_ready,
  input logic        dlm_req,
  input logic [3:0]  dlm_num,
  input logic [15:0] tx_word,
  input logic        tx_k,
  input logic        pkt_open,
  input logic        rx_k,
  input logic        rx_char_valid,
  input logic        rx_corr,
  input logic        rx_uncorr
);

  logic [DLM_LAT:0] sh_req;
  logic [3:0]       sh_num [DLM_LAT+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_req <= '0;
      for (int i = 0; i <= DLM_LAT; i++) sh_num[i] <= '0;
    end else begin
      sh_req[0] <= dlm_req;
      sh_num[0] <= dlm_num;
      for (int i = 1; i <= DLM_LAT; i++) begin
        sh_req[i] <= sh_req[i-1];
        sh_num[i] <= sh_num[i-1];
      end
    end
  end

  AST_DLM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    sh_req[DLM_LAT] |-> (tx_k && tx_word == char_word(CH_DLM, sh_num[DLM_LAT]))); // R2

  AST_DLM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sh_req[DLM_LAT-1] |-> !pkt_ready); // R4

  AST_PKT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |=> (!tx_k && tx_word == $past(pkt_word))); // R3

  AST_CTL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_k && (tx_word == char_word(CH_ACK, 4'h0) || tx_word == char_word(CH_NACK, 4'h0)))
      |-> !$past(pkt_open)); // R5

  AST_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_uncorr |-> (!rx_char_valid && !rx_corr)); // R10

  AST_RX_KOFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rx_k) |-> (!rx_char_valid && !rx_corr && !rx_uncorr)); // R11

endmodule

bind ctl_word_mux ctlw_checker #(.DLM_LAT(DLM_LAT)) u_chk (.*);

// File: tb/sim_ctl_word_mux.sv
module sim_ctl_word_mux;

  localparam int CLK_PERIOD = 10;
  localparam int DLM_LAT    = 2;

  logic        clk;
  logic        rst_n;
  logic        pkt_valid;
  logic [15:0] pkt_word;
  logic        pkt_last;
  logic        pkt_ready;
  logic        ack_req;
  logic        nack_req;
  logic        link_init;
  logic        dlm_req;
  logic [3:0]  dlm_num;
  logic [15:0] tx_word;
  logic        tx_k;
  logic [15:0] rx_word;
  logic        rx_k;
  logic        rx_char_valid;
  logic [2:0]  rx_type;
  logic [3:0]  rx_dlm_num;
  logic        rx_corr;
  logic        rx_uncorr;

  ctl_word_mux #(.DLM_LAT(DLM_LAT)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // stimulus for the next cycle
  logic s_dlm = 0, s_ack = 0, s_nack = 0, s_init = 0, s_gap = 0, s_rxk = 0;
  logic [3:0]  s_num = 0;
  logic [15:0] s_rxw = 0;

  // reference model state
  logic [16:0] src[$];
  int          dq_edge[$];
  logic [3:0]  dq_num[$];
  int          ecount = 0;
  bit          m_open = 0, m_ack = 0, m_nack = 0;
  logic [15:0] e_tx;
  logic        e_k;
  string       e_tag = "R6";
  logic [10:0] e_rx = '0;
  string       e_rtag = "R11";

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] b_h74(input logic [3:0] d);
    logic [7:1] pos;
    int k;
    pos = '0;
    k = 0;
    for (int p = 1; p <= 7; p++) begin
      if ((p & (p - 1)) != 0) begin
        pos[p] = d[k];
        k++;
      end
    end
    for (int p = 1; p <= 4; p = p * 2) begin
      logic x;
      x = 1'b0;
      for (int j = 1; j <= 7; j++)
        if ((j & p) != 0 && (j & (j - 1)) != 0) x = x ^ pos[j];
      pos[p] = x;
    end
    return pos[7:1];
  endfunction

  function automatic logic [3:0] cls_code(input int t);
    case (t)
      0: return 4'h3;
      1: return 4'h5;
      2: return 4'h6;
      3: return 4'h9;
      default: return 4'hA;
    endcase
  endfunction

  function automatic logic [15:0] b_word(input int t, input logic [3:0] n);
    return {2'b00, b_h74((t == 4) ? n : 4'h0), b_h74(cls_code(t))};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, ecount);
    end
  endtask

  task automatic rx_model(input logic [15:0] w, input logic k);
    int best, bt, bn;
    best = 99; bt = 0; bn = 0;
    e_rx = '0;
    e_rtag = "R11";
    if (k) begin
      for (int t = 0; t < 5; t++) begin
        for (int n = 0; n < 16; n++) begin
          int d;
          if (t != 4 && n != 0) continue;
          d = $countones(w ^ b_word(t, 4'(n)));
          if (d < best) begin best = d; bt = t; bn = n; end
        end
      end
      if (best <= 1) begin
        // {valid, corr, uncorr, type, num}
        e_rx = {1'b1, (best == 1), 1'b0, 3'(bt), 4'(bn)};
        e_rtag = (best == 1) ? "R9" : "R8";
      end else begin
        e_rx = {1'b0, 1'b0, 1'b1, 3'd0, 4'd0};
        e_rtag = "R10";
      end
    end
  endtask

  task automatic tick();
    int e;
    bit due, ctl, rdy, take;
    @(negedge clk);
    chk(e_tag, 32'(tx_word), 32'(e_tx));
    chk(e_tag, 32'(tx_k), 32'(e_k));
    chk(e_rtag, 32'({rx_char_valid, rx_corr, rx_uncorr, rx_type, rx_dlm_num}), 32'(e_rx));
    dlm_req   = s_dlm;
    dlm_num   = s_num;
    ack_req   = s_ack;
    nack_req  = s_nack;
    link_init = s_init;
    rx_word   = s_rxw;
    rx_k      = s_rxk;
    pkt_valid = (src.size() > 0) && !s_gap;
    pkt_word  = pkt_valid ? src[0][15:0] : 16'h0;
    pkt_last  = pkt_valid ? src[0][16] : 1'b0;
    #1;
    e = ecount + 1;
    due  = (dq_edge.size() > 0) && (dq_edge[0] == e);
    ctl  = !s_init && !m_open && (m_ack || m_nack);
    rdy  = !due && !s_init && !ctl;
    take = pkt_valid && rdy;
    chk("R4", 32'(pkt_ready), 32'(rdy));
    e_k = 1'b1;
    if (due) begin
      e_tx = b_word(4, dq_num[0]);
      e_tag = "R2 R7";
      void'(dq_edge.pop_front());
      void'(dq_num.pop_front());
    end else if (ctl) begin
      e_tag = "R5 R7";
      if (m_ack) begin e_tx = b_word(2, 4'h0); m_ack = 0; end
      else begin e_tx = b_word(3, 4'h0); m_nack = 0; end
    end else if (take) begin
      e_tx = src[0][15:0];
      e_k = 1'b0;
      m_open = !src[0][16];
      e_tag = "R3";
      void'(src.pop_front());
    end else begin
      e_tx = b_word(s_init ? 1 : 0, 4'h0);
      e_tag = "R6";
    end
    if (s_ack) m_ack = 1;
    if (s_nack) m_nack = 1;
    if (s_dlm) begin
      dq_edge.push_back(e + DLM_LAT - 1 + 1);
      dq_num.push_back(s_num);
    end
    rx_model(s_rxw, s_rxk);
    ecount = e;
    s_dlm = 0; s_ack = 0; s_nack = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic push_pkt(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) src.push_back({(i == n - 1), base + 16'(i)});
  endtask

  initial begin
    rst_n = 1'b0;
    pkt_valid = 0; pkt_word = 0; pkt_last = 0;
    ack_req = 0; nack_req = 0; link_init = 0; dlm_req = 0; dlm_num = 0;
    rx_word = 0; rx_k = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", 32'(tx_word), 32'(b_word(0, 4'h0)));
    chk("R1", 32'(tx_k), 32'd1);
    chk("R1", 32'(pkt_ready), 32'd1);
    chk("R1", 32'({rx_char_valid, rx_corr, rx_uncorr, rx_type, rx_dlm_num}), 32'd0);
    rst_n = 1'b1;
    e_tx = b_word(0, 4'h0);
    e_k = 1'b1;
    idle(3);
    // plain packet
    push_pkt(5, 16'h1000); idle(8);
    // message and acknowledge requested mid-packet
    push_pkt(6, 16'h2000); idle(2);
    s_dlm = 1; s_num = 4'h5; s_ack = 1; tick();
    idle(10);
    // back-to-back messages
    for (int i = 0; i < 4; i++) begin s_dlm = 1; s_num = 4'(i + 1); tick(); end
    idle(5);
    // both acknowledges together between packets
    s_ack = 1; s_nack = 1; tick(); idle(4);
    // negative ack while a packet streams
    push_pkt(4, 16'h3000); s_nack = 1; tick(); idle(8);
    // packet with source gaps and a message inside a gap
    push_pkt(5, 16'h4000);
    for (int i = 0; i < 12; i++) begin
      s_gap = (i % 3 == 1);
      if (i == 4) begin s_dlm = 1; s_num = 4'hC; end
      tick();
    end
    s_gap = 0;
    // messages at packet start and second word
    push_pkt(3, 16'h5000);
    s_dlm = 1; s_num = 4'h9; tick();
    s_dlm = 1; s_num = 4'hF; tick();
    idle(8);
    // link training holds packets and acknowledges, messages still go out
    push_pkt(3, 16'h6000);
    s_init = 1; s_ack = 1; tick(); idle(2);
    s_dlm = 1; s_num = 4'h3; tick(); idle(4);
    s_init = 0; idle(8);
    // receive: every valid character
    s_rxk = 1;
    for (int t = 0; t < 5; t++)
      for (int n = 0; n < 16; n++) begin
        if (t != 4 && n != 0) continue;
        s_rxw = b_word(t, 4'(n)); tick();
      end
    // every single-bit flip
    for (int t = 0; t < 5; t++)
      for (int b = 0; b < 16; b++) begin
        s_rxw = b_word(t, 4'h6) ^ (16'h1 << b); tick();
      end
    // double flips
    for (int t = 0; t < 5; t++)
      for (int b = 0; b < 13; b++) begin
        s_rxw = b_word(t, 4'hB) ^ (16'h1 << b) ^ (16'h1 << (b + 3)); tick();
      end
    s_rxw = 16'hFFFF; tick();
    s_rxw = 16'h1234; tick();
    s_rxw = 16'hC000; tick();
    // k-flag clear: no character
    s_rxk = 0; s_rxw = b_word(4, 4'h7); tick();
    s_rxw = 16'hFFFF; tick();
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule